// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block sits between up to 32 peripheral request lines, a non-maskable request input and a processor core. It picks the single most urgent request that is enabled and not masked. For that request it presents an exception number and the address of the vector-table slot that holds the handler pointer. Per-line enables, per-line priority levels, a global mask bit and a base-priority threshold are held in a small configuration register file. The core writes and reads that file over a simple single-cycle port.

The core takes a presented interrupt by pulsing `irq_take` while `irq_valid` is high. The block then records the active exception. While that record is held, only strictly more urgent requests are presented. A pulse on `irq_return` ends the active state. Outputs follow the request lines and the register state combinationally, so a change written at a clock edge is visible in the same cycle that follows.

Register map (word addresses on `cfg_addr`):
- 0: set-enable.
- 1: clear-enable.
- 2: global mask, in bit 0.
- 3: base priority, in bits 2:0.
- 4: active status, read only. Bit 31 is the valid flag and bits 5:0 hold the exception number.
- 32+n: priority of line n, in bits 2:0.

Any other address reads as zero.

Top module: `vir_resolver`

## Requirements
- R1: After reset the following all hold: every enable bit is 0, every priority field is 0, the global mask is 0, base priority is 0, no exception is active, and `irq_valid` is 0 when `nmi_req` is low.
- R2: A write to address 0 enables each line whose data bit is 1 and leaves the other lines unchanged. Reading address 0 or address 1 returns the current 32 enable bits.
- R3: A write to address 1 disables each line whose data bit is 1 and leaves the other lines unchanged.
- R4: Request line n is presented with exception number 16+n. NMI is presented with exception number 2. The vector address is the exception number times four, so line 0 gives 0x40, line 18 gives 0x88 and NMI gives 0x08.
- R5: Among eligible lines, the one with the numerically lowest priority value wins. When priority values are equal, the lower exception number wins.
- R6: While the global mask bit is 1, no peripheral line is presented. NMI is still presented.
- R7: With base priority 0, no line is blocked by the threshold. With a nonzero base priority, a line whose priority value is greater than or equal to it is blocked.
- R8: An NMI request is presented ahead of every line and ignores the enables, the global mask and the base priority.
- R9: `irq_take` while `irq_valid` is high records the presented exception. From the next cycle it is shown on `active_valid` and `active_excnum`, and at address 4.
- R10: While an exception is active, a line is presented only if its priority value is lower than that of the active one. An active peripheral exception is always outranked by NMI, and an active NMI blocks everything.
- R11: `irq_return` without `irq_take` clears the active state in the next cycle. If both arrive in the same cycle, the take wins.
- R12: A write to address 32+n stores bits 2:0 as the priority of line n, and a read of that address returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 32 | Level requests from the peripheral lines |
| nmi_req | input | 1 | Non-maskable request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| irq_take | input | 1 | Core accepts the presented exception |
| irq_return | input | 1 | Core has returned from the active handler |
| irq_valid | output | 1 | An exception is being presented |
| irq_excnum | output | 6 | Exception number presented |
| irq_vector | output | 32 | Vector-table address of the presented exception |
| active_valid | output | 1 | An exception is active |
| active_excnum | output | 6 | Exception number of the active exception |

## Verification
The hardest situation to reach is one where several filters act on the same request: an active handler whose level competes with pending lines that are also cut by a nonzero threshold, by a tie in priority, or by a mask. Directed steps take a line at level 5 and then raise a second line at equal and then lower priority values. They also take an NMI and show that nothing, including NMI itself, is presented afterwards. Random cycles then mix sparse requests, priority and threshold writes, and take and return pulses. A bench model of the enables, levels and active record predicts every output and every read.

// File: rtl/vir_pkg.sv
// Package: shared constants and register address codes for the resolver.
// Assumes the peripheral line count is a power of two of at least 8.
package vir_pkg;
    localparam int SYS_EXC_COUNT = 16;   // exception numbers below this are system ones
    localparam int NMI_EXC       = 2;    // exception number used for NMI

    typedef enum logic [2:0] {
        REG_SETEN   = 3'd0,
        REG_CLREN   = 3'd1,
        REG_GMASK   = 3'd2,
        REG_BASEPRI = 3'd3,
        REG_ACTIVE  = 3'd4
    } vir_reg_e;
endpackage

// File: rtl/vir_cfg_regs.sv
// Module: configuration register file. It holds the line enables, the per-line
// priority fields, the global mask and the base-priority threshold, and it
// returns read data combinationally.
// Assumes NUM_LINES is a power of two with 8 <= NUM_LINES <= DATA_W. The
// priority region starts at address NUM_LINES.
module vir_cfg_regs
    import vir_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 3,
    parameter int DATA_W    = 32,
    parameter int EXC_W     = 6,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int ADDR_W   = IDX_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        act_valid,
    input  logic [EXC_W-1:0]            act_exc,
    output logic [NUM_LINES-1:0]        en,
    output logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        gmask,
    output logic [PRIO_W-1:0]           basepri,
    output logic [DATA_W-1:0]           rdata
);
    logic             in_prio_region;
    logic [IDX_W-1:0] line_sel;

    assign in_prio_region = addr[ADDR_W-1];
    assign line_sel       = addr[IDX_W-1:0];

    // Enable bits: set on 1s at the set address, clear on 1s at the clear address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (we && addr == ADDR_W'(REG_SETEN)) begin
            en <= en | wdata[NUM_LINES-1:0];
        end else if (we && addr == ADDR_W'(REG_CLREN)) begin
            en <= en & ~wdata[NUM_LINES-1:0];
        end
    end

    // Global mask and base-priority threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gmask   <= 1'b0;
            basepri <= '0;
        end else if (we && addr == ADDR_W'(REG_GMASK)) begin
            gmask <= wdata[0];
        end else if (we && addr == ADDR_W'(REG_BASEPRI)) begin
            basepri <= wdata[PRIO_W-1:0];
        end
    end

    // One priority field per line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_prio
        logic [PRIO_W-1:0] level_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_q <= '0;
            end else if (we && in_prio_region && line_sel == IDX_W'(g)) begin
                level_q <= wdata[PRIO_W-1:0];
            end
        end
        assign prio_flat[g*PRIO_W +: PRIO_W] = level_q;
    end

    // Read mux over the address space.
    always_comb begin
        rdata = '0;
        if (in_prio_region) begin
            rdata[PRIO_W-1:0] = prio_flat[line_sel*PRIO_W +: PRIO_W];
        end else begin
            case (addr)
                ADDR_W'(REG_SETEN),
                ADDR_W'(REG_CLREN):   rdata[NUM_LINES-1:0] = en;
                ADDR_W'(REG_GMASK):   rdata[0] = gmask;
                ADDR_W'(REG_BASEPRI): rdata[PRIO_W-1:0] = basepri;
                ADDR_W'(REG_ACTIVE): begin
                    rdata[DATA_W-1]  = act_valid;
                    rdata[EXC_W-1:0] = act_exc;
                end
                default:              rdata = '0;
            endcase
        end
    end

    p_set_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(REG_SETEN)) |=>
            ((en & $past(wdata[NUM_LINES-1:0])) == $past(wdata[NUM_LINES-1:0]))
            && ((en & ~$past(wdata[NUM_LINES-1:0])) == ($past(en) & ~$past(wdata[NUM_LINES-1:0]))));

    p_clear_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(REG_CLREN)) |=>
            ((en & $past(wdata[NUM_LINES-1:0])) == '0)
            && ((en & ~$past(wdata[NUM_LINES-1:0])) == ($past(en) & ~$past(wdata[NUM_LINES-1:0]))));
endmodule

// File: rtl/vir_gate.sv
// Module: per-line eligibility filter. A line is eligible when it is
// requesting, enabled, not globally masked, below the base-priority
// threshold (when that threshold is nonzero), and strictly more urgent than
// the active exception. Urgency rank = priority + 1; rank 0 belongs to NMI.
// Assumes the active rank is only meaningful while act_valid is high.
module vir_gate #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 3,
    localparam int RANK_W   = PRIO_W + 1
) (
    input  logic [NUM_LINES-1:0]        req,
    input  logic [NUM_LINES-1:0]        en,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    input  logic                        gmask,
    input  logic [PRIO_W-1:0]           basepri,
    input  logic                        act_valid,
    input  logic [RANK_W-1:0]           act_rank,
    output logic [NUM_LINES-1:0]        elig
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [PRIO_W-1:0] level;
        logic [RANK_W-1:0] rank;
        logic              under_thresh;
        logic              beats_active;

        assign level        = prio_flat[g*PRIO_W +: PRIO_W];
        assign rank         = RANK_W'(level) + RANK_W'(1);
        // Threshold check: zero threshold disables it.
        assign under_thresh = (basepri == '0) || (level < basepri);
        // Nesting check: only strictly more urgent than the active one.
        assign beats_active = !act_valid || (rank < act_rank);
        assign elig[g]      = req[g] && en[g] && !gmask && under_thresh && beats_active;
    end
endmodule

// File: rtl/vir_pick.sv
// Module: winner selection among eligible lines. The lowest priority value
// wins, and on equal values the lowest line index (lowest exception number)
// wins.
// Assumes elig already includes every masking condition.
module vir_pick #(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 3,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        elig,
    input  logic [NUM_LINES*PRIO_W-1:0] prio_flat,
    output logic                        any,
    output logic [IDX_W-1:0]            win_idx,
    output logic [PRIO_W-1:0]           win_prio
);
    // Linear scan; the strict compare keeps the earlier index on ties.
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (elig[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                any      = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

    p_winner_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> elig[win_idx]);

    p_any_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any == (elig != '0));
endmodule

// File: rtl/vir_active.sv
// Module: single-level active record. A take stores the presented exception
// and its rank; a return clears the record. A take in the same cycle as a
// return wins.
// Assumes the core only pulses take while a presentation is valid; a take
// without one is ignored.
module vir_active #(
    parameter int EXC_W  = 6,
    parameter int RANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              ret,
    input  logic              pres_valid,
    input  logic [EXC_W-1:0]  pres_exc,
    input  logic [RANK_W-1:0] pres_rank,
    output logic              act_valid,
    output logic [EXC_W-1:0]  act_exc,
    output logic [RANK_W-1:0] act_rank
);
    // Record on accept, drop on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_exc   <= '0;
            act_rank  <= '0;
        end else if (take && pres_valid) begin
            act_valid <= 1'b1;
            act_exc   <= pres_exc;
            act_rank  <= pres_rank;
        end else if (ret) begin
            act_valid <= 1'b0;
        end
    end

    p_take_records_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pres_valid) |=> act_valid && act_exc == $past(pres_exc));

    p_return_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !(take && pres_valid)) |=> !act_valid);
endmodule

// File: rtl/vir_resolver.sv
// Module: top of the vectored interrupt priority resolver. It combines the
// configuration registers, the per-line filter, the winner scan, the NMI
// override and the active record, and it forms exception number and vector
// address.
// Assumes the vector table starts at address zero with 4-byte slots.
module vir_resolver
    import vir_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int PRIO_W    = 3,
    parameter int DATA_W    = 32,
    parameter int VEC_W     = 32,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int ADDR_W   = IDX_W + 1,
    localparam int EXC_W    = $clog2(SYS_EXC_COUNT + NUM_LINES),
    localparam int RANK_W   = PRIO_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 nmi_req,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic                 irq_take,
    input  logic                 irq_return,
    output logic                 irq_valid,
    output logic [EXC_W-1:0]     irq_excnum,
    output logic [VEC_W-1:0]     irq_vector,
    output logic                 active_valid,
    output logic [EXC_W-1:0]     active_excnum
);
    logic [NUM_LINES-1:0]        en;
    logic [NUM_LINES*PRIO_W-1:0] prio_flat;
    logic                        gmask;
    logic [PRIO_W-1:0]           basepri;
    logic [NUM_LINES-1:0]        elig;
    logic                        any;
    logic [IDX_W-1:0]            win_idx;
    logic [PRIO_W-1:0]           win_prio;
    logic [RANK_W-1:0]           act_rank;
    logic                        nmi_ok;
    logic [RANK_W-1:0]           pres_rank;

    vir_cfg_regs #(
        .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .EXC_W(EXC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .act_valid(active_valid), .act_exc(active_excnum),
        .en(en), .prio_flat(prio_flat), .gmask(gmask), .basepri(basepri),
        .rdata(cfg_rdata)
    );

    vir_gate #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_gate (
        .req(irq_req), .en(en), .prio_flat(prio_flat), .gmask(gmask),
        .basepri(basepri), .act_valid(active_valid), .act_rank(act_rank),
        .elig(elig)
    );

    vir_pick #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .elig(elig), .prio_flat(prio_flat),
        .any(any), .win_idx(win_idx), .win_prio(win_prio)
    );

    // NMI override: rank 0, blocked only by an active NMI.
    assign nmi_ok = nmi_req && !(active_valid && act_rank == '0);

    // Presentation: NMI first, else the scanned winner.
    always_comb begin
        if (nmi_ok) begin
            irq_valid  = 1'b1;
            irq_excnum = EXC_W'(NMI_EXC);
            pres_rank  = '0;
        end else begin
            irq_valid  = any;
            irq_excnum = EXC_W'(SYS_EXC_COUNT) + EXC_W'(win_idx);
            pres_rank  = RANK_W'(win_prio) + RANK_W'(1);
        end
    end

    // Vector slot address: exception number scaled by the 4-byte slot size.
    assign irq_vector = VEC_W'({irq_excnum, 2'b00});

    vir_active #(.EXC_W(EXC_W), .RANK_W(RANK_W)) u_active (
        .clk(clk), .rst_n(rst_n), .take(irq_take), .ret(irq_return),
        .pres_valid(irq_valid), .pres_exc(irq_excnum), .pres_rank(pres_rank),
        .act_valid(active_valid), .act_exc(active_excnum), .act_rank(act_rank)
    );

    p_nmi_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !active_valid) |-> (irq_valid && irq_excnum == EXC_W'(NMI_EXC)));

    p_gmask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gmask && irq_valid) |-> irq_excnum == EXC_W'(NMI_EXC));

    p_exc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_excnum != EXC_W'(NMI_EXC)) |-> irq_excnum >= EXC_W'(SYS_EXC_COUNT));

    p_no_self_nest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active_valid && irq_valid) |-> irq_excnum != active_excnum);
endmodule

// File: tb/tb_vir_resolver.sv
`timescale 1ns/1ps
module tb_vir_resolver;
    localparam int NL = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic        nmi_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_take = 1'b0;
    logic        irq_return = 1'b0;
    logic        irq_valid;
    logic [5:0]  irq_excnum;
    logic [31:0] irq_vector;
    logic        active_valid;
    logic [5:0]  active_excnum;

    int checks = 0;
    int fails  = 0;

    // Bench model state
    logic [31:0] m_en;
    logic [2:0]  m_prio [NL];
    logic        m_gmask;
    logic [2:0]  m_bp;
    logic        m_act;
    int          m_exc;
    int          m_rank;

    always #2 clk = ~clk;

    vir_resolver dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_take(irq_take), .irq_return(irq_return),
        .irq_valid(irq_valid), .irq_excnum(irq_excnum), .irq_vector(irq_vector),
        .active_valid(active_valid), .active_excnum(active_excnum)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string tag, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void model_pick(input logic [31:0] req, input logic nmi,
                                       output logic v, output int exc, output int rank);
        v = 1'b0; exc = 0; rank = 99;
        if (nmi && !(m_act && m_rank == 0)) begin
            v = 1'b1; exc = 2; rank = 0;
            return;
        end
        if (m_gmask) return;
        for (int i = 0; i < NL; i++) begin
            if (req[i] && m_en[i] && (m_bp == 0 || m_prio[i] < m_bp)) begin
                int r;
                r = int'(m_prio[i]) + 1;
                if ((!m_act || r < m_rank) && r < rank) begin
                    v = 1'b1; exc = 16 + i; rank = r;
                end
            end
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [5:0] a);
        logic [31:0] d;
        d = '0;
        if (a[5]) d[2:0] = m_prio[a[4:0]];
        else case (a)
            6'd0, 6'd1: d = m_en;
            6'd2:       d[0] = m_gmask;
            6'd3:       d[2:0] = m_bp;
            6'd4: begin d[31] = m_act; d[5:0] = 6'(m_exc); end
            default:    d = '0;
        endcase
        return d;
    endfunction

    // One clock cycle: drive, check outputs against model, clock, update model.
    task automatic cyc(input logic [31:0] req, input logic nmi, input logic we,
                       input logic [5:0] a, input logic [31:0] wd,
                       input logic take, input logic ret, input string tag);
        logic ev; int eexc; int erank;
        irq_req = req; nmi_req = nmi; cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        irq_take = take; irq_return = ret;
        #1;
        model_pick(req, nmi, ev, eexc, erank);
        chk({31'd0, irq_valid}, {31'd0, ev}, tag, "irq_valid");
        if (ev) begin
            chk({26'd0, irq_excnum}, 32'(eexc), tag, "irq_excnum");
            chk(irq_vector, 32'(eexc * 4), tag, "irq_vector");
        end
        chk({31'd0, active_valid}, {31'd0, m_act}, tag, "active_valid");
        if (m_act) chk({26'd0, active_excnum}, 32'(m_exc), tag, "active_excnum");
        chk(cfg_rdata, model_read(a), tag, "cfg_rdata");
        @(posedge clk);
        if (we) begin
            if (a[5]) m_prio[a[4:0]] = wd[2:0];
            else case (a)
                6'd0: m_en = m_en | wd;
                6'd1: m_en = m_en & ~wd;
                6'd2: m_gmask = wd[0];
                6'd3: m_bp = wd[2:0];
                default: ;
            endcase
        end
        if (take && ev) begin
            m_act = 1'b1; m_exc = eexc; m_rank = erank;
        end else if (ret) begin
            m_act = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] wd, input string tag);
        cyc('0, 1'b0, 1'b1, a, wd, 1'b0, 1'b0, tag);
    endtask

    task automatic obs(input logic [31:0] req, input logic nmi, input logic [5:0] a,
                       input string tag);
        cyc(req, nmi, 1'b0, a, '0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(4 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_en = '0; m_gmask = 1'b0; m_bp = '0; m_act = 1'b0; m_exc = 0; m_rank = 0;
        for (int i = 0; i < NL; i++) m_prio[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        obs(32'hFFFF_FFFF, 1'b0, 6'd0, "R1");
        obs('0, 1'b0, 6'd3, "R1");
        obs('0, 1'b0, 6'd2, "R1");
        obs('0, 1'b0, 6'd37, "R1");
        obs('0, 1'b0, 6'd4, "R1");

        // R2 set-enable and readback
        wr(6'd0, 32'h0004_0001, "R2");
        obs('0, 1'b0, 6'd1, "R2");
        wr(6'd0, 32'h0000_0000, "R2");
        obs('0, 1'b0, 6'd0, "R2");

        // R4 vector addresses
        obs(32'h0000_0001, 1'b0, 6'd0, "R4");
        obs(32'h0004_0000, 1'b0, 6'd0, "R4");
        obs(32'h0000_0002, 1'b0, 6'd0, "R4");   // disabled line, R2

        // R12 priority field write and read
        wr(6'd50, 32'hFFFF_FFFD, "R12");
        obs('0, 1'b0, 6'd50, "R12");

        // R5 ordering
        obs(32'h0004_0001, 1'b0, 6'd32, "R5");
        wr(6'd32, 32'd6, "R5");
        obs(32'h0004_0001, 1'b0, 6'd32, "R5");
        wr(6'd32, 32'd5, "R5");
        obs(32'h0004_0001, 1'b0, 6'd0, "R5");

        // R7 base priority
        wr(6'd3, 32'd5, "R7");
        obs(32'h0004_0001, 1'b0, 6'd3, "R7");
        wr(6'd3, 32'd6, "R7");
        obs(32'h0004_0001, 1'b0, 6'd3, "R7");
        wr(6'd3, 32'd0, "R7");

        // R6 global mask, R8 NMI
        wr(6'd2, 32'd1, "R6");
        obs(32'h0004_0001, 1'b0, 6'd2, "R6");
        obs(32'h0004_0001, 1'b1, 6'd2, "R8");
        wr(6'd2, 32'd0, "R6");
        obs(32'h0000_0100, 1'b1, 6'd0, "R8");

        // R3 clear-enable
        wr(6'd1, 32'h0000_0001, "R3");
        obs(32'h0004_0001, 1'b0, 6'd0, "R3");
        wr(6'd1, 32'h0000_0000, "R3");
        obs(32'h0004_0001, 1'b0, 6'd1, "R3");

        // R9 take, R10 nesting, R11 return
        wr(6'd0, 32'h0000_0001, "R10");
        cyc(32'h0004_0000, 1'b0, 1'b0, 6'd4, '0, 1'b1, 1'b0, "R9");
        obs(32'h0004_0001, 1'b0, 6'd4, "R10");
        wr(6'd32, 32'd4, "R10");
        obs(32'h0004_0001, 1'b0, 6'd4, "R10");
        cyc(32'h0004_0001, 1'b1, 1'b0, 6'd4, '0, 1'b1, 1'b0, "R9");
        obs(32'h0004_0001, 1'b1, 6'd4, "R10");
        cyc('0, 1'b0, 1'b0, 6'd4, '0, 1'b0, 1'b1, "R11");
        obs(32'h0004_0001, 1'b0, 6'd4, "R11");
        cyc(32'h0004_0000, 1'b0, 1'b0, 6'd4, '0, 1'b1, 1'b1, "R11");
        obs('0, 1'b0, 6'd4, "R11");
        cyc('0, 1'b0, 1'b0, 6'd4, '0, 1'b0, 1'b1, "R11");

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] rq; logic nm; logic we; logic [5:0] a; logic [31:0] wd;
            int sel;
            rq = $urandom() & $urandom() & $urandom();
            nm = ($urandom_range(0, 19) == 0);
            we = ($urandom_range(0, 3) == 0);
            sel = $urandom_range(0, 9);
            case (sel)
                0: a = 6'd0;
                1: a = 6'd1;
                2: a = 6'd2;
                3: a = 6'd3;
                4: a = 6'd4;
                5: a = 6'(5 + $urandom_range(0, 26));
                default: a = 6'(32 + $urandom_range(0, 31));
            endcase
            wd = $urandom();
            if (we && a == 6'd2) wd = {31'd0, ($urandom_range(0, 3) == 0)};
            if (we && a == 6'd1) wd = wd & $urandom();
            cyc(rq, nm, we, a, wd, ($urandom_range(0, 2) == 0),
                ($urandom_range(0, 4) == 0), "R5");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule